// File: doc/BRIEF.md
# Timed Message Display Sequencer

This block runs a one-shot display session armed by a slide switch. The switch is resynchronised to the system clock. A low-to-high transition starts a session of fixed length, counted in whole seconds of system clock cycles. While the session runs, the block sends a two-digit elapsed-seconds readout to a character display, once at the start and again at every second boundary. When the session expires, it writes a fixed six-letter message and switches on a bank of indicator LEDs. The block then holds that state until the switch is lowered. Lowering the switch turns the LEDs off and blanks the display, and the next raise arms a fresh session.

Characters leave the block one byte at a time over a write/ready handshake towards a separate character-LCD writer. Each byte carries a register-select flag: low marks a command and high marks character data. Every screen of text begins with a clear-display command, so the downstream writer never needs to track cursor position. Nibble timing, display power-up and pin mapping are handled downstream.

Top module: `msg_session_seq`

## Requirements
- R1: Only a low-to-high transition of the switch, seen after a two-flop synchronizer, starts a session from idle. A switch that stays high, or that falls and rises again during a session, neither restarts nor extends it.
- R2: Count the first rising clock edge at which the switch input is high as edge 1. The LED output becomes all ones right after edge SESSION_SECS*CYC_PER_SEC+3 and is all zeros right after the edge before it.
- R3: Every screen starts with the clear command, byte 0x01 with register-select 0. Every other byte is sent with register-select 1.
- R4: At session start and at each second boundary k (1 ≤ k < SESSION_SECS), the block sends one screen: clear, then the ASCII tens digit, then the ASCII ones digit of k. Digit d is sent as 0x30+d, so a session of 10 seconds shows 00 through 09.
- R5: At expiry the block sends one screen: clear, then 0x41, 0x42, 0x43, 0x44, 0x45, 0x46 (A to F) in that order.
- R6: The LEDs are all zeros before expiry. They are all ones from expiry for as long as the switch stays high, and no further bytes are sent during that time.
- R7: After expiry, lowering the switch drives the LEDs to zero and sends exactly one clear command. A later raise starts a new session that behaves exactly like the first one.
- R8: The write strobe rises only in a cycle following one in which ready was high. It stays high for exactly two cycles. The next strobe waits until ready has returned high.
- R9: A synchronous active-high reset returns the block to idle: LEDs zero, strobe low, and no pending write sent afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_i | input | 1 | Asynchronous slide switch level |
| wr_ready_i | input | 1 | Downstream writer can accept a byte |
| wr_strobe_o | output | 1 | Write strobe, held two cycles per byte |
| wr_rs_o | output | 1 | Register select: 0 command, 1 character |
| wr_byte_o | output | 8 | Command or ASCII character byte |
| led_o | output | LED_W | Indicator LED bank |

## Verification
The bench times the LED rise to the exact edge after the switch raise. A design that counted one cycle too many or too few in its synchronizer, its start logic or its seconds counter shows up as an LED change one edge early or late. Part-way through a session, the switch is dropped and raised again. A design that treated that second edge as a fresh start would push back the expiry and send extra readout screens. The bench compares the whole byte stream of a session against the computed screen sequence, which catches a missing clear, wrong register-select levels, a readout reaching the terminal count, and misordered letters. A reset during a session with a write in flight must leave the LEDs dark and the strobe silent, and a strobe pulse of one or three cycles is counted as a fault.

// File: rtl/msg_seq_pkg.sv
package msg_seq_pkg;
    typedef enum logic [1:0] {SCR_CLEAR, SCR_COUNT, SCR_END} scr_kind_e;
    typedef enum logic [1:0] {CT_IDLE, CT_RUN, CT_DONE} ctl_st_e;
    typedef enum logic [1:0] {WR_IDLE, WR_SEND, WR_HOLD1, WR_HOLD2} wr_st_e;

    localparam logic [7:0] CMD_CLEAR  = 8'h01;
    localparam logic [7:0] ASCII_ZERO = 8'h30;
    localparam logic [7:0] ASCII_A    = 8'h41;
endpackage

// File: rtl/msg_sw_sync.sv
module msg_sw_sync (
    input  logic clk,
    input  logic rst,
    input  logic sw_i,
    output logic level_o,
    output logic rise_o
);
    logic [2:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[1:0], sw_i};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign level_o = sh_q[1];
    assign rise_o  = sh_q[1] & ~sh_q[2];

    p_rise_single_r1: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/msg_sec_timer.sv
module msg_sec_timer #(
    parameter int unsigned CYC_PER_SEC = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (CYC_PER_SEC > 1) ? $clog2(CYC_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_SEC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)            cnt_d = '0;
        else if (en_i)        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign tick_o = en_i && !clr_i && (cnt_q == LAST);

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
endmodule

// File: rtl/msg_char_writer.sv
module msg_char_writer
    import msg_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_i,
    input  scr_kind_e  kind_i,
    input  logic [3:0] tens_i,
    input  logic [3:0] ones_i,
    input  logic       ready_i,
    output logic       strobe_o,
    output logic       rs_o,
    output logic [7:0] byte_o
);
    typedef struct packed {
        wr_st_e     st;
        logic [2:0] idx;
        scr_kind_e  kind;
        logic [3:0] tens;
        logic [3:0] ones;
        logic       pend;
        scr_kind_e  pkind;
        logic [3:0] ptens;
        logic [3:0] pones;
        logic       strobe;
        logic       rs;
        logic [7:0] data;
    } wr_t;

    wr_t d, q;
    logic [2:0] last_idx;
    logic [7:0] cur_byte;

    always_comb begin
        case (q.kind)
            SCR_CLEAR: last_idx = 3'd0;
            SCR_COUNT: last_idx = 3'd2;
            default:   last_idx = 3'd6;
        endcase
        if (q.idx == 3'd0)          cur_byte = CMD_CLEAR;
        else if (q.kind == SCR_COUNT)
            cur_byte = ASCII_ZERO + {4'd0, (q.idx == 3'd1) ? q.tens : q.ones};
        else                        cur_byte = ASCII_A + {5'd0, q.idx - 3'd1};
    end

    always_comb begin
        d = q;
        case (q.st)
            WR_IDLE: if (q.pend) begin
                d.pend = 1'b0;
                d.kind = q.pkind;
                d.tens = q.ptens;
                d.ones = q.pones;
                d.idx  = 3'd0;
                d.st   = WR_SEND;
            end
            WR_SEND: if (ready_i) begin
                d.strobe = 1'b1;
                d.data   = cur_byte;
                d.rs     = (q.idx != 3'd0);
                d.st     = WR_HOLD1;
            end
            WR_HOLD1: d.st = WR_HOLD2;
            default: begin
                d.strobe = 1'b0;
                d.idx    = q.idx + 3'd1;
                d.st     = (q.idx == last_idx) ? WR_IDLE : WR_SEND;
            end
        endcase
        if (req_i) begin
            d.pend  = 1'b1;
            d.pkind = kind_i;
            d.ptens = tens_i;
            d.pones = ones_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= '0;
            q.st     <= WR_IDLE;
            q.kind   <= SCR_CLEAR;
            q.pkind  <= SCR_CLEAR;
        end else begin
            q <= d;
        end
    end

    assign strobe_o = q.strobe;
    assign rs_o     = q.rs;
    assign byte_o   = q.data;

    p_strobe_ready_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_o) |-> $past(ready_i));
    p_strobe_hold_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_o) |=> strobe_o);
    p_strobe_end_r8: assert property (@(posedge clk) disable iff (rst)
        (strobe_o && $past(strobe_o)) |=> !strobe_o);
    p_clear_cmd_r3: assert property (@(posedge clk) disable iff (rst)
        (strobe_o && !rs_o) |-> (byte_o == CMD_CLEAR));
endmodule

// File: rtl/msg_session_seq.sv
module msg_session_seq
    import msg_seq_pkg::*;
#(
    parameter int unsigned CYC_PER_SEC  = 50_000_000,
    parameter int unsigned SESSION_SECS = 10,
    parameter int unsigned LED_W        = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_i,
    input  logic             wr_ready_i,
    output logic             wr_strobe_o,
    output logic             wr_rs_o,
    output logic [7:0]       wr_byte_o,
    output logic [LED_W-1:0] led_o
);
    localparam int SECW = $clog2(SESSION_SECS + 1);
    localparam logic [SECW-1:0] SEC_LAST = SECW'(SESSION_SECS - 1);

    typedef struct packed {
        ctl_st_e         st;
        logic [SECW-1:0] sec;
        logic [3:0]      tens;
        logic [3:0]      ones;
        logic [LED_W-1:0] leds;
    } ctl_t;

    ctl_t d, q;
    logic sw_lvl, sw_rise, tick, start, req;
    scr_kind_e req_kind;

    msg_sw_sync u_sync (
        .clk(clk), .rst(rst), .sw_i(sw_i), .level_o(sw_lvl), .rise_o(sw_rise)
    );

    assign start = (q.st == CT_IDLE) && sw_rise;

    msg_sec_timer #(.CYC_PER_SEC(CYC_PER_SEC)) u_timer (
        .clk(clk), .rst(rst), .clr_i(start), .en_i(q.st == CT_RUN), .tick_o(tick)
    );

    always_comb begin
        d        = q;
        req      = 1'b0;
        req_kind = SCR_CLEAR;
        case (q.st)
            CT_IDLE: if (sw_rise) begin
                d.st   = CT_RUN;
                d.sec  = '0;
                d.tens = 4'd0;
                d.ones = 4'd0;
                req      = 1'b1;
                req_kind = SCR_COUNT;
            end
            CT_RUN: if (tick) begin
                d.sec = q.sec + 1'b1;
                if (q.sec == SEC_LAST) begin
                    d.st     = CT_DONE;
                    d.leds   = '1;
                    req      = 1'b1;
                    req_kind = SCR_END;
                end else begin
                    if (q.ones == 4'd9) begin
                        d.ones = 4'd0;
                        d.tens = q.tens + 4'd1;
                    end else begin
                        d.ones = q.ones + 4'd1;
                    end
                    req      = 1'b1;
                    req_kind = SCR_COUNT;
                end
            end
            default: if (!sw_lvl) begin
                d.st   = CT_IDLE;
                d.leds = '0;
                req      = 1'b1;
                req_kind = SCR_CLEAR;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            q.st <= CT_IDLE;
        end else begin
            q <= d;
        end
    end

    msg_char_writer u_writer (
        .clk(clk), .rst(rst), .req_i(req), .kind_i(req_kind),
        .tens_i(d.tens), .ones_i(d.ones), .ready_i(wr_ready_i),
        .strobe_o(wr_strobe_o), .rs_o(wr_rs_o), .byte_o(wr_byte_o)
    );

    assign led_o = q.leds;

    p_start_edge_r1: assert property (@(posedge clk) disable iff (rst)
        (q.st == CT_RUN && $past(q.st) == CT_IDLE) |-> $past(sw_rise));
    p_led_expiry_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(led_o[0]) |-> ($past(tick) && $past(q.sec) == SEC_LAST));
    p_sec_bound_r4: assert property (@(posedge clk) disable iff (rst)
        q.sec <= SECW'(SESSION_SECS));
    p_led_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (q.st == CT_DONE && sw_lvl) |=> $stable(led_o));
endmodule

// File: tb/msg_session_seq_tb.sv
module msg_session_seq_tb;
    localparam int CPS = 40;
    localparam int SECS = 10;
    localparam int EXPIRE_EDGE = SECS * CPS + 3;
    localparam int SESSION_LEN = SECS * 3 + 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sw = 1'b0;
    logic rdy = 1'b1;
    logic strobe, rs;
    logic [7:0] wbyte;
    logic [7:0] leds;

    int checks = 0;
    int failures = 0;
    logic [8:0] lg [0:63];
    int lg_n = 0;
    int run = 0;
    int busy = 0;

    always #2 clk = ~clk;

    msg_session_seq #(.CYC_PER_SEC(CPS), .SESSION_SECS(SECS), .LED_W(8)) u_dut (
        .clk(clk), .rst(rst), .sw_i(sw), .wr_ready_i(rdy),
        .wr_strobe_o(strobe), .wr_rs_o(rs), .wr_byte_o(wbyte), .led_o(leds)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Downstream writer model plus strobe protocol monitor (R8)
    always @(negedge clk) begin
        if (strobe && run == 0) chk("R8 strobe rise needs ready", 32'(rdy), 32'd1);
        if (strobe) run++;
        else if (run > 0) begin
            chk("R8 strobe width", 32'(run), 32'd2);
            run = 0;
        end
        if (strobe && rdy) begin
            if (lg_n < 64) lg[lg_n] = {rs, wbyte};
            lg_n++;
            rdy  = 1'b0;
            busy = 3;
        end else if (busy > 0) begin
            busy--;
            if (busy == 0) rdy = 1'b1;
        end
    end

    function automatic logic [8:0] exp_entry(input int e);
        int s, j;
        if (e < SECS * 3) begin
            s = e / 3;
            j = e % 3;
            if (j == 0) return {1'b0, 8'h01};
            if (j == 1) return {1'b1, 8'(8'h30 + s / 10)};
            return {1'b1, 8'(8'h30 + s % 10)};
        end
        j = e - SECS * 3;
        if (j == 0) return {1'b0, 8'h01};
        return {1'b1, 8'(8'h40 + j)};
    endfunction

    task automatic check_session_log();
        chk("R4 bytes per session", 32'(lg_n), 32'(SESSION_LEN));
        for (int e = 0; e < SESSION_LEN && e < 64; e++) begin
            if (e >= SECS * 3) chk("R5 end message byte", 32'(lg[e]), 32'(exp_entry(e)));
            else if (e % 3 == 0) chk("R3 clear command", 32'(lg[e]), 32'(exp_entry(e)));
            else chk("R4 readout digit", 32'(lg[e]), 32'(exp_entry(e)));
        end
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 leds after reset", 32'(leds), 32'h0);
        chk("R9 strobe after reset", 32'(strobe), 32'h0);

        repeat (50) @(negedge clk);
        chk("R1 no writes while switch low", 32'(lg_n), 32'd0);

        // Session 1
        sw = 1'b1;
        repeat (EXPIRE_EDGE - 1) @(negedge clk);
        chk("R2 leds off before expiry", 32'(leds), 32'h0);
        @(negedge clk);
        chk("R2 leds on at expiry", 32'(leds), 32'hFF);
        repeat (120) @(negedge clk);
        check_session_log();
        repeat (100) @(negedge clk);
        chk("R6 leds held while switch high", 32'(leds), 32'hFF);
        chk("R6 no bytes after end message", 32'(lg_n), 32'(SESSION_LEN));

        // Lower the switch after expiry
        lg_n = 0;
        sw = 1'b0;
        repeat (10) @(negedge clk);
        chk("R7 leds off after lowering", 32'(leds), 32'h0);
        repeat (60) @(negedge clk);
        chk("R7 single clear on lowering", 32'(lg_n), 32'd1);
        chk("R7 clear command byte", 32'(lg[0]), 32'h001);

        // Session 2 with a switch bounce mid-session
        lg_n = 0;
        sw = 1'b1;
        repeat (200) @(negedge clk);
        sw = 1'b0;
        repeat (6) @(negedge clk);
        sw = 1'b1;
        repeat (EXPIRE_EDGE - 1 - 206) @(negedge clk);
        chk("R1 bounce does not extend session", 32'(leds), 32'h0);
        @(negedge clk);
        chk("R1 expiry timed from first raise", 32'(leds), 32'hFF);
        repeat (120) @(negedge clk);
        check_session_log();

        // Lower, then reset mid-session
        sw = 1'b0;
        repeat (80) @(negedge clk);
        sw = 1'b1;
        repeat (150) @(negedge clk);
        sw = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        lg_n = 0;
        @(negedge clk);
        chk("R9 leds after mid-session reset", 32'(leds), 32'h0);
        chk("R9 strobe after mid-session reset", 32'(strobe), 32'h0);
        repeat (500) @(negedge clk);
        chk("R9 no writes after reset", 32'(lg_n), 32'd0);
        chk("R9 leds stay off", 32'(leds), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule